// File: doc/BRIEF.md
# On-Off Keying Bit Timer

This block paces an on-off keyed transmitter one bit at a time. Software puts one bit in a single-entry buffer, which is the DATA field of the control register. The timer moves that bit onto the key output and then holds it for a slot. The slot length comes from a 10-bit count value. The upper two bits of that value sit in the control register and the lower eight bits sit in the count register. When the timer takes a bit, it raises a buffer-empty flag so that software can supply the next bit. When a slot ends and no new bit is waiting, the timer raises a done flag and releases the key. Any line coding, such as Manchester or pulse-width coding, is built in software from these single bits.

The same 10-bit counter does two other jobs. In receive mode it counts up from zero and measures the time between edges on an input pin. On each edge it stores the elapsed count into the count fields, records the new pin level in the DATA field, and starts again from zero. In interval mode it counts down once from the programmed value and then raises the done flag, and it never keys the transmitter. Both flags can be read by polling. Each flag can also drive its own interrupt request through an enable bit.

Top module: `ook_bit_timer`

## Requirements
- R1: After reset the key output and both interrupt requests are low, and all four registers read 0x00.
- R2: The register map is as follows. Address 0 is the count low byte (read/write). Address 1 is the control register: bits [7:6] are count bits [9:8], bit 2 is DATA, and bits [1:0] are the mode (0 idle, 1 transmit, 2 receive, 3 interval); bits [5:3] read zero. Address 2 is the interrupt enable register: bit 0 enables the buffer-empty request and bit 1 enables the done request. Address 3 holds the flags: bit 0 is buffer-empty/capture and bit 1 is done. Unused bits read zero.
- R3: In transmit mode, a control write arms the one-bit buffer. On the next clock the timer copies DATA to the key output, sets flag bit 0, and starts a slot.
- R4: Each transmit slot lasts countval+1 clock cycles, where countval = {control[7:6], count[7:0]}. This holds from countval 0 up to 10-bit values.
- R5: When a slot ends and the buffer is empty, the timer sets flag bit 1, drives the key low, and stops.
- R6: In receive mode the input pin passes through two synchronising flops. The third clock edge after a pin change captures the counter into the count fields, sets flag bit 0, and restarts the count at zero. A pulse lasting N cycles therefore reads back as N-1. The flag is still clear two cycles after the pin change.
- R7: In receive mode, a captured rising edge sets DATA to 1 and a captured falling edge clears DATA to 0.
- R8: In interval mode a control write loads the counter on the next clock. Flag bit 1 then sets countval+1 cycles after that load. The key stays low in this mode even when DATA is 1, and flag bit 0 stays clear.
- R9: Writing 1 to a flag bit clears it. Writing 0 leaves the flag unchanged.
- R10: Each interrupt request is high exactly while its flag and its enable bit are both 1. A masked flag can still be read by polling.
- R11: Writing the idle mode drives the key low on the following clock and stops any slot in progress, so no done flag is set afterwards. The key is low in every mode other than transmit.
- R12: In receive mode the count saturates at 1023 instead of wrapping, so an over-long pulse reads back as 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| pinIn | input | 1 | Asynchronous pulse input for receive mode |
| keyOut | output | 1 | Transmitter key (high = carrier on) |
| irqBufEmpty | output | 1 | Buffer-empty / capture interrupt request |
| irqDone | output | 1 | Transmission-done / interval-elapsed request |

## Verification
The bound assertions check four things on every cycle. The key stays low outside transmit mode. The key rises only in the same cycle as a buffer take. The done flag rises only in transmit or interval mode, and the key is low when it does. In receive mode the counter restarts at zero on a capture and never wraps once saturated. The scenarios show behaviour that only a measurement or a register read can reveal: exact slot widths for short, zero and 10-bit count values; the captured pulse widths and edge polarity together with the synchronizer latency; the interval expiry cycle; the write-one-to-clear semantics; interrupt masking; and the stop on return to idle.

// File: rtl/ook_bt_pkg.sv
package ook_bt_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2,
    MODE_TIM  = 2'd3
  } btMode_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int DATA_POS = 2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic cntInc;
    logic cntClear;
    logic capture;
    logic keyTake;
    logic keyDrop;
    logic setBuf;
    logic setDone;
  } btStrobe_t;

endpackage

// File: rtl/ook_bt_ctrl.sv
module ook_bt_ctrl
  import ook_bt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  btMode_e   mode,
  input  logic      wrCtrl,
  input  btMode_e   wrMode,
  input  logic      cntZero,
  input  logic      edgeSeen,
  output btStrobe_t strobe
);

  logic pending, pendNext;
  logic running, runNext;
  logic modeSwitch;

  assign modeSwitch = wrCtrl && (wrMode != mode);

  always_comb begin
    strobe   = '0;
    pendNext = pending;
    runNext  = running;
    if (modeSwitch) begin
      strobe.cntClear = 1'b1;
      runNext  = 1'b0;
      pendNext = 1'b0;
    end else begin
      unique case (mode)
        MODE_IDLE: begin
          runNext  = 1'b0;
          pendNext = 1'b0;
        end
        MODE_TX, MODE_TIM: begin
          if (pending && (!running || cntZero)) begin
            strobe.cntLoad = 1'b1;
            strobe.keyTake = (mode == MODE_TX);
            strobe.setBuf  = (mode == MODE_TX);
            runNext  = 1'b1;
            pendNext = 1'b0;
          end else if (running && cntZero) begin
            strobe.setDone = 1'b1;
            strobe.keyDrop = 1'b1;
            runNext = 1'b0;
          end else if (running) begin
            strobe.cntDec = 1'b1;
          end
        end
        MODE_RX: begin
          if (edgeSeen) begin
            strobe.capture = 1'b1;
            strobe.setBuf  = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (mode != MODE_TX) strobe.keyDrop = 1'b1;
    if (wrCtrl && (wrMode == MODE_TX || wrMode == MODE_TIM)) pendNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      running <= 1'b0;
    end else begin
      pending <= pendNext;
      running <= runNext;
    end
  end

endmodule

// File: rtl/ook_bt_datapath.sv
module ook_bt_datapath
  import ook_bt_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int EXT_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            addr,
  input  logic [LO_W-1:0]       wrData,
  output logic [LO_W-1:0]       rdData,
  input  logic                  pinIn,
  input  btStrobe_t             strobe,
  output btMode_e               mode,
  output logic                  wrCtrl,
  output btMode_e               wrMode,
  output logic                  cntZero,
  output logic                  edgeSeen,
  output logic                  key,
  output logic                  flagBuf,
  output logic                  flagDone,
  output logic                  ienBuf,
  output logic                  ienDone,
  output logic [LO_W+EXT_W-1:0] cntValue
);

  localparam int CNT_W = LO_W + EXT_W;
  localparam int PAD_W = LO_W - EXT_W - DATA_POS - 1;

  logic [LO_W-1:0]  cntLo;
  logic [EXT_W-1:0] cntExt;
  logic             dataBit;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       syncQ;
  logic             prevQ;
  logic             wrCnt, wrIen, wrFlag;

  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);
  assign wrCnt    = wrEn && (addr == ADDR_CNT);
  assign wrIen    = wrEn && (addr == ADDR_IEN);
  assign wrFlag   = wrEn && (addr == ADDR_FLAG);
  assign wrMode   = btMode_e'(wrData[1:0]);
  assign cntZero  = (cnt == '0);
  assign edgeSeen = syncQ[1] ^ prevQ;
  assign cntValue = cnt;

  // two-flop synchronizer plus edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pinIn};
      prevQ <= syncQ[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntLo <= '0;
    else if (strobe.capture) cntLo <= cnt[LO_W-1:0];
    else if (wrCnt) cntLo <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntExt  <= '0;
      dataBit <= 1'b0;
      mode    <= MODE_IDLE;
    end else begin
      if (wrCtrl) begin
        cntExt  <= wrData[LO_W-1 -: EXT_W];
        dataBit <= wrData[DATA_POS];
        mode    <= wrMode;
      end
      if (strobe.capture) begin
        cntExt  <= cnt[CNT_W-1 -: EXT_W];
        dataBit <= syncQ[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobe.cntClear || strobe.capture) cnt <= '0;
    else if (strobe.cntLoad) cnt <= {cntExt, cntLo};
    else if (strobe.cntDec) cnt <= cnt - 1'b1;
    else if (strobe.cntInc && (cnt != '1)) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) key <= 1'b0;
    else if (strobe.keyTake) key <= dataBit;
    else if (strobe.keyDrop) key <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ienBuf  <= 1'b0;
      ienDone <= 1'b0;
    end else if (wrIen) begin
      ienBuf  <= wrData[0];
      ienDone <= wrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagBuf  <= 1'b0;
      flagDone <= 1'b0;
    end else begin
      if (wrFlag && wrData[0]) flagBuf  <= 1'b0;
      if (wrFlag && wrData[1]) flagDone <= 1'b0;
      if (strobe.setBuf)  flagBuf  <= 1'b1;
      if (strobe.setDone) flagDone <= 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CNT:  rdData = cntLo;
      ADDR_CTRL: rdData = {cntExt, {PAD_W{1'b0}}, dataBit, mode};
      ADDR_IEN:  rdData = {{(LO_W-2){1'b0}}, ienDone, ienBuf};
      default:   rdData = {{(LO_W-2){1'b0}}, flagDone, flagBuf};
    endcase
  end

endmodule

// File: rtl/ook_bit_timer.sv
module ook_bit_timer
  import ook_bt_pkg::*;
#(
  parameter int CNT_LO_W  = 8,
  parameter int CNT_EXT_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          addr,
  input  logic [CNT_LO_W-1:0] wrData,
  output logic [CNT_LO_W-1:0] rdData,
  input  logic                pinIn,
  output logic                keyOut,
  output logic                irqBufEmpty,
  output logic                irqDone
);

  localparam int CNT_W = CNT_LO_W + CNT_EXT_W;

  btStrobe_t        strobe;
  btMode_e          modeQ;
  btMode_e          wrMode;
  logic             wrCtrl, cntZero, edgeSeen;
  logic             flagBuf, flagDone, ienBuf, ienDone;
  logic [CNT_W-1:0] cntValue;

  ook_bt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(modeQ), .wrCtrl(wrCtrl), .wrMode(wrMode),
    .cntZero(cntZero), .edgeSeen(edgeSeen), .strobe(strobe)
  );

  ook_bt_datapath #(.LO_W(CNT_LO_W), .EXT_W(CNT_EXT_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .strobe(strobe), .mode(modeQ),
    .wrCtrl(wrCtrl), .wrMode(wrMode), .cntZero(cntZero), .edgeSeen(edgeSeen),
    .key(keyOut), .flagBuf(flagBuf), .flagDone(flagDone), .ienBuf(ienBuf),
    .ienDone(ienDone), .cntValue(cntValue)
  );

  assign irqBufEmpty = flagBuf & ienBuf;
  assign irqDone     = flagDone & ienDone;

endmodule

// File: rtl/ook_bt_checker.sv
module ook_bt_checker
  import ook_bt_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             key,
  input logic             flagBuf,
  input logic             flagDone,
  input logic [CNT_W-1:0] cnt
);

  assert_key_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_TX && $past(mode) != MODE_TX) |-> !key);

  assert_key_rise_take_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(key) |-> flagBuf);

  assert_done_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDone) |-> ($past(mode) == MODE_TX || $past(mode) == MODE_TIM));

  assert_done_key_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDone) |-> !key);

  assert_rx_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MODE_RX && mode == MODE_RX && $rose(flagBuf)) |-> (cnt == '0));

  assert_rx_saturate_R12: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MODE_RX && mode == MODE_RX && $past(cnt) == '1)
      |-> (cnt == '1 || cnt == '0));

endmodule

bind ook_bit_timer ook_bt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(modeQ), .key(keyOut),
  .flagBuf(flagBuf), .flagDone(flagDone), .cnt(cntValue)
);

// File: tb/ook_bit_timer_tb.sv
module ook_bit_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       pinIn = 1'b0;
  logic       keyOut, irqBufEmpty, irqDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  ook_bit_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .keyOut(keyOut),
    .irqBufEmpty(irqBufEmpty), .irqDone(irqDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge, returns at the following negedge
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdData);
  endtask

  task automatic waitKey(input logic lvl, input int startCyc, output int width);
    int guard = 0;
    while (keyOut !== lvl && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    width = cyc - startCyc;
  endtask

  task automatic goIdle();
    busWrite(2'd1, 8'h00);
    busWrite(2'd3, 8'h03);
  endtask

  task automatic testReset();
    int v;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 key reset", int'(keyOut), 0);
    check("R1 irq reset", int'({irqBufEmpty, irqDone}), 0);
  endtask

  task automatic testRegs();
    int v;
    busWrite(2'd0, 8'hA5);
    readReg(2'd0, v); check("R2 count readback", v, 'hA5);
    busWrite(2'd1, 8'hFC);
    readReg(2'd1, v); check("R2 control readback", v, 'hC4);
    busWrite(2'd2, 8'hFF);
    readReg(2'd2, v); check("R2 enable readback", v, 'h03);
    busWrite(2'd1, 8'h00);
  endtask

  task automatic testTxSlots();
    int v, c0, w;
    busWrite(2'd0, 8'd3);
    busWrite(2'd1, 8'h05);
    check("R3 key before take", int'(keyOut), 0);
    @(negedge clk);
    c0 = cyc;
    check("R3 key after take", int'(keyOut), 1);
    readReg(2'd3, v); check("R3 buffer flag on take", v, 'h01);
    check("R10 buffer irq", int'(irqBufEmpty), 1);
    busWrite(2'd3, 8'h01);
    busWrite(2'd1, 8'h01);
    readReg(2'd3, v); check("R9 buffer flag cleared", v, 0);
    waitKey(1'b0, c0, w); check("R4 slot width one", w, 4);
    readReg(2'd3, v); check("R3 second take flag", v, 'h01);
    c0 = cyc;
    busWrite(2'd3, 8'h01);
    busWrite(2'd1, 8'h05);
    waitKey(1'b1, c0, w); check("R4 slot width zero", w, 4);
    c0 = cyc;
    waitKey(1'b0, c0, w); check("R4 last slot width", w, 4);
    readReg(2'd3, v); check("R5 done flag", v & 2, 2);
    check("R10 done irq", int'(irqDone), 1);
    repeat (10) @(negedge clk);
    check("R5 key stays low after done", int'(keyOut), 0);
    goIdle();
  endtask

  task automatic testLongSlot();
    int c0, w, v;
    busWrite(2'd0, 8'h05);
    busWrite(2'd1, 8'h45);
    @(negedge clk);
    c0 = cyc;
    check("R4 long slot key", int'(keyOut), 1);
    waitKey(1'b0, c0, w); check("R4 10-bit slot width", w, 262);
    readReg(2'd3, v); check("R5 done after long slot", v & 2, 2);
    goIdle();
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, 8'h05);
    @(negedge clk);
    c0 = cyc;
    waitKey(1'b0, c0, w); check("R4 countval zero width", w, 1);
    goIdle();
  endtask

  task automatic testIdleStop();
    int v;
    busWrite(2'd0, 8'd50);
    busWrite(2'd1, 8'h05);
    @(negedge clk);
    check("R11 key high before stop", int'(keyOut), 1);
    busWrite(2'd3, 8'h01);
    busWrite(2'd1, 8'h00);
    @(negedge clk);
    check("R11 key low after idle", int'(keyOut), 0);
    repeat (80) @(negedge clk);
    readReg(2'd3, v); check("R11 no done after idle", v, 0);
    check("R11 key still low", int'(keyOut), 0);
  endtask

  task automatic testTimer();
    int v;
    int keySeen = 0;
    busWrite(2'd2, 8'h03);
    busWrite(2'd0, 8'd5);
    busWrite(2'd1, 8'h07);
    repeat (6) begin
      @(negedge clk);
      keySeen |= int'(keyOut);
    end
    readReg(2'd3, v); check("R8 done not yet", v, 0);
    @(negedge clk);
    readReg(2'd3, v); check("R8 done at countval+1", v, 'h02);
    check("R8 done irq", int'(irqDone), 1);
    check("R8 key never keyed", keySeen, 0);
    busWrite(2'd3, 8'h00);
    readReg(2'd3, v); check("R9 write zero keeps flag", v, 'h02);
    busWrite(2'd3, 8'h01);
    readReg(2'd3, v); check("R9 other bit keeps flag", v, 'h02);
    busWrite(2'd3, 8'h02);
    readReg(2'd3, v); check("R9 write one clears", v, 0);
    busWrite(2'd1, 8'h00);
  endtask

  task automatic testMask();
    int v;
    busWrite(2'd2, 8'h00);
    busWrite(2'd0, 8'd0);
    busWrite(2'd1, 8'h03);
    repeat (4) @(negedge clk);
    readReg(2'd3, v); check("R10 masked flag polled", v, 'h02);
    check("R10 masked irq low", int'(irqDone), 0);
    busWrite(2'd2, 8'h02);
    check("R10 enable raises irq", int'(irqDone), 1);
    goIdle();
  endtask

  task automatic testRx();
    int v;
    int keySeen = 0;
    busWrite(2'd1, 8'h02);
    repeat (5) @(negedge clk);
    pinIn = 1'b1;
    repeat (2) @(negedge clk);
    readReg(2'd3, v); check("R6 sync latency", v, 0);
    @(negedge clk);
    readReg(2'd3, v); check("R6 capture flag", v, 'h01);
    readReg(2'd1, v); check("R7 rising sets data", v & 4, 4);
    busWrite(2'd3, 8'h01);
    repeat (6) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    readReg(2'd0, v); check("R6 short pulse count", v, 9);
    readReg(2'd1, v); check("R7 falling clears data", v, 'h02);
    busWrite(2'd3, 8'h01);
    repeat (296) begin
      @(negedge clk);
      keySeen |= int'(keyOut);
    end
    pinIn = 1'b1;
    repeat (3) @(negedge clk);
    readReg(2'd0, v); check("R6 long pulse low byte", v, 'h2B);
    readReg(2'd1, v); check("R6 long pulse ext bits", v, 'h46);
    busWrite(2'd3, 8'h01);
    repeat (1096) @(negedge clk);
    pinIn = 1'b0;
    repeat (3) @(negedge clk);
    readReg(2'd0, v); check("R12 saturated low byte", v, 'hFF);
    readReg(2'd1, v); check("R12 saturated ext bits", v, 'hC2);
    check("R11 key low in receive", keySeen, 0);
    goIdle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0h expected=%0h", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    busWrite(2'd2, 8'h03);
    testTxSlots();
    testLongSlot();
    testIdleStop();
    testTimer();
    testMask();
    testRx();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule